// File: doc/BRIEF.md
# Double-Buffered Transform Frame Controller

This block sequences image-transform frames for a resampling engine. Software or a host writes transform parameters into a preload bank through a chip-selected write port. The pixel scanner reads a separate working bank. The controller copies preload into working at two points: while an initialise request is held, and on the first advancing clock of the final line of each frame. This lets the next frame's parameters be staged while the current frame is still running.

After initialisation there is a fixed start latency before the first-pixel pulse. At each frame end, a run/halt input decides what happens next. If it is high, the next frame starts back to back. If it is low, the controller parks until run/halt is raised again. A step enable freezes the countdown and the frame sequencing while it is low. The pixel address arithmetic lives outside this block. The scanner reports its final-line and frame-end conditions on dedicated inputs.

Top module: `xfc_top`

## Requirements
- R1: Reset clears both banks and leaves the controller idle (run_o=0, start_o=0, work_o=0). While idle, sync_i and the scanner inputs have no effect. Only init_i leaves idle.
- R2: At every clock edge at which init_i is sampled high, work_o is loaded with the preload bank as it stood before that edge, and run_o is 0 after that edge.
- R3: Suppose init_i is sampled high at edge k and low at edges k+1 to k+9, with step_en_i high. Then run_o and start_o first become 1 after edge k+9 (START_LAT=9).
- R4: An edge in the running state with step_en_i=1, frame_end_i=1 and sync_i=1 pulses start_o after that edge, and run_o stays 1.
- R5: The working bank loads from preload exactly once per frame. This happens at the first edge in the running state with step_en_i=1 and last_line_i=1. A preload write landing after that edge shows up only at the next frame's load.
- R6: An edge in the running state with step_en_i=1, frame_end_i=1 and sync_i=0 drops run_o. The controller then halts, work_o holds, and frame_end_i and last_line_i are ignored.
- R7: In the halted state, the first edge with sync_i=1 sets run_o and pulses start_o after that edge.
- R8: cs_i is registered. A write (wr_i=1) at an edge is dropped if cs_i was 1 at the previous edge, and accepted if cs_i was 0 there. The word goes to preload entry wr_addr_i, entries 0..N_REG-1.
- R9: While step_en_i=0, the start countdown, the final-line load and the frame-end decision do not advance.
- R10: start_o is high only while run_o is high. It falls one clock after it rises unless another frame start follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Initialise request, sampled on the clock |
| sync_i | input | 1 | Run/halt: 1 continues at frame end, 0 halts |
| step_en_i | input | 1 | Scanner advance enable, 0 freezes sequencing |
| cs_i | input | 1 | Preload chip select, 1 disables writes one clock later |
| wr_i | input | 1 | Preload write strobe |
| wr_addr_i | input | AW | Preload entry index |
| wr_data_i | input | DW | Preload write data |
| last_line_i | input | 1 | Scanner is on the final line of the frame |
| frame_end_i | input | 1 | Scanner is on the final pixel of the frame |
| work_o | output | N_REG*DW | Working parameters, entry i at bits i*DW +: DW |
| run_o | output | 1 | Transform is active |
| start_o | output | 1 | First-pixel pulse of a frame |

## Verification
The bench counts clocks after init_i falls. A countdown that is one short or one long moves start_o off edge k+9. A stall that does not pause the countdown makes start_o appear early.

It writes preload twice: once before the final line and once inside it. A bank that loads on every final-line clock, or at frame end, would expose the second value one frame too early.

It drops and raises cs_i in the same cycle as a write. An unregistered chip select would accept the write that must be lost.

It asserts frame_end_i while halted and with step_en_i low. A controller that reacts to either one would restart or halt out of turn.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_WAIT,
    ST_RUN,
    ST_HALT
  } xfc_state_e;
endpackage

// File: rtl/xfc_preload_bank.sv
module xfc_preload_bank #(
  parameter int N_REG = 4,
  parameter int DW    = 16,
  parameter int AW    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_i,
  input  logic                wr_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       data_i,
  output logic [N_REG*DW-1:0] bank_o
);
  logic cs_q;
  logic wr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b0;
    else         cs_q <= cs_i;
  end

  assign wr_ok = wr_i && !cs_q;

  for (genvar g = 0; g < N_REG; g++) begin : g_ent
    logic [DW-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ent_q <= '0;
      else if (wr_ok && (int'(addr_i) == g))         ent_q <= data_i;
    end
    assign bank_o[g*DW +: DW] = ent_q;
  end

  // R8: chip select seen high one clock earlier blocks every write
  p_cs_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |=> $stable(bank_o));
endmodule

// File: rtl/xfc_work_bank.sv
module xfc_work_bank #(
  parameter int N_REG = 4,
  parameter int DW    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [N_REG*DW-1:0] src_i,
  output logic [N_REG*DW-1:0] work_o
);
  for (genvar g = 0; g < N_REG; g++) begin : g_ent
    logic [DW-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ent_q <= '0;
      else if (load_i) ent_q <= src_i[g*DW +: DW];
    end
    assign work_o[g*DW +: DW] = ent_q;
  end

  p_work_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(work_o));
endmodule

// File: rtl/xfc_seq.sv
module xfc_seq
  import xfc_pkg::*;
#(
  parameter int START_LAT = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic sync_i,
  input  logic step_en_i,
  input  logic last_line_i,
  input  logic frame_end_i,
  output logic load_o,
  output logic run_o,
  output logic start_o
);
  localparam int CW       = (START_LAT > 2) ? $clog2(START_LAT) : 1;
  localparam int CNT_LAST = START_LAT - 2;

  xfc_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          xfer_q, xfer_d;
  logic          run_d, start_d;
  logic          adv_run;

  assign adv_run = (state_q == ST_RUN) && step_en_i;
  assign load_o  = init_i || (!init_i && adv_run && last_line_i && !xfer_q);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    xfer_d  = xfer_q;
    run_d   = run_o;
    start_d = 1'b0;
    if (init_i) begin
      state_d = ST_INIT;
      run_d   = 1'b0;
      xfer_d  = 1'b0;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_INIT: begin
          state_d = ST_WAIT;
          cnt_d   = '0;
        end
        ST_WAIT: if (step_en_i) begin
          if (int'(cnt_q) == CNT_LAST) begin
            state_d = ST_RUN;
            run_d   = 1'b1;
            start_d = 1'b1;
            xfer_d  = 1'b0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_RUN: if (step_en_i) begin
          if (last_line_i) xfer_d = 1'b1;
          if (frame_end_i) begin
            xfer_d = 1'b0;
            if (sync_i) start_d = 1'b1;
            else begin
              state_d = ST_HALT;
              run_d   = 1'b0;
            end
          end
        end
        ST_HALT: if (sync_i) begin
          state_d = ST_RUN;
          run_d   = 1'b1;
          start_d = 1'b1;
          xfer_d  = 1'b0;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      xfer_q  <= 1'b0;
      run_o   <= 1'b0;
      start_o <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      xfer_q  <= xfer_d;
      run_o   <= run_d;
      start_o <= start_d;
    end
  end

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !init_i) |=> (!run_o && !start_o));
  p_init_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (!run_o && !start_o));
  p_lat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && int'(cnt_q) == CNT_LAST && step_en_i && !init_i)
      |=> (run_o && start_o));
  p_cont_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_run && frame_end_i && sync_i && !init_i) |=> (run_o && start_o));
  p_halt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_run && frame_end_i && !sync_i && !init_i) |=> !run_o);
  p_resume_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT && sync_i && !init_i) |=> (run_o && start_o));
  p_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !step_en_i && !init_i) |=> ($stable(cnt_q) && !run_o));
endmodule

// File: rtl/xfc_top.sv
module xfc_top #(
  parameter int N_REG     = 4,
  parameter int DW        = 16,
  parameter int START_LAT = 9,
  parameter int AW        = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                init_i,
  input  logic                sync_i,
  input  logic                step_en_i,
  input  logic                cs_i,
  input  logic                wr_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [DW-1:0]       wr_data_i,
  input  logic                last_line_i,
  input  logic                frame_end_i,
  output logic [N_REG*DW-1:0] work_o,
  output logic                run_o,
  output logic                start_o
);
  logic [N_REG*DW-1:0] pre_bank;
  logic                load;

  xfc_preload_bank #(.N_REG(N_REG), .DW(DW), .AW(AW)) i_pre (
    .clk_i (clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .wr_i(wr_i),
    .addr_i(wr_addr_i), .data_i(wr_data_i), .bank_o(pre_bank)
  );

  xfc_seq #(.START_LAT(START_LAT)) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .sync_i(sync_i),
    .step_en_i(step_en_i), .last_line_i(last_line_i),
    .frame_end_i(frame_end_i), .load_o(load), .run_o(run_o),
    .start_o(start_o)
  );

  xfc_work_bank #(.N_REG(N_REG), .DW(DW)) i_work (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .src_i(pre_bank),
    .work_o(work_o)
  );

  p_start_run_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> run_o);
endmodule

// File: tb/test_xfc_top.sv
module test_xfc_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_REG = 4;
  localparam int DW = 16;
  localparam int AW = 2;
  localparam int LAT = 9;

  logic clk = 0, rst_n = 0;
  logic init_i = 0, sync_i = 0, step = 1, cs = 0, wr = 0;
  logic [AW-1:0] wa = '0;
  logic [DW-1:0] wd = '0;
  logic ll = 0, fe = 0;
  logic [N_REG*DW-1:0] work;
  logic run, start;

  int errs = 0, checks = 0;
  string cur_req = "R1";
  bit chk_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfc_top #(.N_REG(N_REG), .DW(DW), .START_LAT(LAT)) i_xfc_top (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init_i), .sync_i(sync_i),
    .step_en_i(step), .cs_i(cs), .wr_i(wr), .wr_addr_i(wa), .wr_data_i(wd),
    .last_line_i(ll), .frame_end_i(fe), .work_o(work), .run_o(run),
    .start_o(start)
  );

  // behavioural reference: 0 idle, 1 init, 2 wait, 3 run, 4 halt
  int m_st, m_cnt;
  bit m_xfer, m_run, m_start, m_csq;
  logic [DW-1:0] m_pre[N_REG];
  logic [DW-1:0] m_work[N_REG];

  always @(posedge clk or negedge rst_n) begin
    logic [DW-1:0] old[N_REG];
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_xfer = 0; m_run = 0; m_start = 0; m_csq = 0;
      for (int i = 0; i < N_REG; i++) begin m_pre[i] = '0; m_work[i] = '0; end
    end else begin
      for (int i = 0; i < N_REG; i++) old[i] = m_pre[i];
      if (wr && !m_csq) m_pre[wa] = wd;
      m_csq = cs;
      m_start = 0;
      if (init_i) begin
        m_st = 1; m_run = 0; m_xfer = 0; m_cnt = 0;
        for (int i = 0; i < N_REG; i++) m_work[i] = old[i];
      end else if (m_st == 1) begin
        m_st = 2; m_cnt = 0;
      end else if (m_st == 2 && step) begin
        if (m_cnt == LAT - 2) begin m_st = 3; m_run = 1; m_start = 1; end
        else m_cnt++;
      end else if (m_st == 3 && step) begin
        if (ll && !m_xfer) begin
          m_xfer = 1;
          for (int i = 0; i < N_REG; i++) m_work[i] = old[i];
        end
        if (fe) begin
          m_xfer = 0;
          if (sync_i) m_start = 1;
          else begin m_st = 4; m_run = 0; end
        end
      end else if (m_st == 4 && sync_i) begin
        m_st = 3; m_run = 1; m_start = 1; m_xfer = 0;
      end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_en && rst_n) begin
    chk(cur_req, "run_o", run, m_run);
    chk(cur_req, "start_o", start, m_start);
    for (int i = 0; i < N_REG; i++)
      chk(cur_req, $sformatf("work[%0d]", i), work[i*DW +: DW], m_work[i]);
  end

  function automatic logic [DW-1:0] wget(int i);
    return work[i*DW +: DW];
  endfunction

  task automatic write(int a, int d);
    wr = 1; wa = AW'(a); wd = DW'(d);
    @(negedge clk);
    wr = 0;
  endtask

  task automatic do_init();
    init_i = 1; @(negedge clk);
    init_i = 0;
  endtask

  // lines x ppl frame; optional write at first pixel of line wl; stall every third pixel if gap
  task automatic frame(int lines, int ppl, bit sv, bit gap, int wl, int wadr, int wdat);
    sync_i = sv;
    for (int l = 0; l < lines; l++)
      for (int p = 0; p < ppl; p++) begin
        ll = (l == lines - 1);
        fe = (l == lines - 1) && (p == ppl - 1);
        if (gap && (p % 3 == 1)) begin step = 0; @(negedge clk); end
        step = 1;
        if (l == wl && p == 0) begin wr = 1; wa = AW'(wadr); wd = DW'(wdat); end
        @(negedge clk);
        wr = 0;
      end
    ll = 0; fe = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", "run after reset", run, 0);
    chk("R1", "work after reset", work, 0);
    rst_n = 1; chk_en = 1;
    sync_i = 1; fe = 1; ll = 1;
    repeat (5) @(negedge clk);
    chk("R1", "idle ignores sync", run, 0);
    sync_i = 0; fe = 0; ll = 0;

    cur_req = "R8";
    write(0, 'hA0); write(1, 'hA1); write(2, 'hA2); write(3, 'hA3);
    cs = 1; @(negedge clk);
    write(0, 'hBAD);               // blocked: cs seen high
    cs = 0; write(1, 'hBAD);       // blocked: cs still registered high
    write(3, 'hC3);                // accepted

    cur_req = "R2";
    do_init();
    chk("R2", "init loads work[0]", wget(0), 'hA0);
    chk("R8", "write after cs high dropped", wget(1), 'hA1);
    chk("R8", "write after cs low accepted", wget(3), 'hC3);
    chk("R2", "run low during init", run, 0);
    cur_req = "R3";
    for (int i = 1; i <= LAT - 1; i++) begin
      @(negedge clk);
      chk("R3", $sformatf("no start at edge k+%0d", i), start, 0);
    end
    @(negedge clk);
    chk("R3", "start at edge k+9", start, 1);
    chk("R3", "run at edge k+9", run, 1);
    @(negedge clk);
    chk("R10", "start one cycle", start, 0);

    cur_req = "R5";
    frame(3, 4, 1, 0, 0, 1, 'h1111);
    chk("R5", "mid-frame write taken at final line", wget(1), 'h1111);
    chk("R4", "start after frame end with sync", start, 1);
    cur_req = "R4";
    frame(3, 4, 1, 0, 2, 2, 'h2222);
    chk("R5", "final-line write deferred", wget(2), 'hA2);
    chk("R4", "continuous run", run, 1);

    cur_req = "R6";
    frame(2, 5, 0, 1, -1, 0, 0);
    chk("R5", "deferred write applied next frame", wget(2), 'h2222);
    chk("R6", "halt after sync low", run, 0);
    write(0, 'h5555);
    step = 1; fe = 1; ll = 1;
    repeat (4) @(negedge clk);
    fe = 0; ll = 0;
    chk("R6", "halted ignores frame_end", run, 0);
    chk("R6", "work holds while halted", wget(0), 'hA0);

    cur_req = "R7";
    sync_i = 1; @(negedge clk);
    chk("R7", "resume start", start, 1);
    chk("R7", "resume run", run, 1);

    cur_req = "R9";
    step = 0; fe = 1; ll = 1;
    repeat (6) @(negedge clk);
    chk("R9", "stalled frame_end ignored", start, 0);
    chk("R9", "stalled keeps work", wget(0), 'hA0);
    fe = 0; ll = 0; step = 1;
    frame(2, 3, 1, 1, -1, 0, 0);
    chk("R5", "preload reaches work", wget(0), 'h5555);
    do_init();
    step = 0;
    repeat (12) @(negedge clk);
    chk("R9", "countdown frozen", start, 0);
    step = 1;
    repeat (LAT + 2) @(negedge clk);
    chk("R9", "countdown completes", run, 1);

    cur_req = "R10";
    frame(1, 1, 1, 0, -1, 0, 0);
    frame(1, 2, 0, 0, -1, 0, 0);
    repeat (3) @(negedge clk);
    chk_en = 0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule